// File: doc/BRIEF.md
# Serial Debug Request Serializer

This block is the host-side transmitter for the request phase of a two-wire serial debug link. A one-cycle start strobe captures a request made of three fields. The first selects the debug port or an access port. The second says whether the access reads or writes. The third is a two-bit register address carrying address bits [3:2]. The block forms the eight-bit request header, including its even parity, and shifts it out one bit per clock on a single data output. A separate output enable tells the pad when the host is driving the line.

For a write, the 32-bit data word follows the header directly. It goes out least-significant bit first and is closed by its own even-parity bit. A one-cycle done pulse marks the end of every transfer. A strobe that arrives while bits are still being shifted is ignored. A strobe that arrives in the done cycle starts the next request at once. Acknowledge sampling, turnaround cycles, line reset and clock generation belong to neighbouring logic.

Top module: `swd_req_ser`

## Requirements
- R1: While reset is high, and in the first cycle after it, `sdo_o`, `sdo_oe_o` and `done_o` are 0.
- R2: In the cycles after an accepted strobe, the header is driven with `sdo_oe_o`=1 in this order: start bit 1, then `dbg_sel_i` (1 = debug port, 0 = access port), then `rd_i` (1 = read, 0 = write), then `addr_i[0]` (address bit 2), then `addr_i[1]` (address bit 3).
- R3: The sixth header bit is the XOR of `dbg_sel_i`, `rd_i`, `addr_i[0]` and `addr_i[1]`. This makes the number of ones across those five bits even.
- R4: The seventh header bit is a stop bit, driven to 0 with `sdo_oe_o`=1.
- R5: In the eighth header bit (park) `sdo_oe_o` is 0. Whenever `sdo_oe_o` is 0, `sdo_o` is 0.
- R6: For a read, no data follows the park bit. `done_o` is 1 in the ninth cycle after acceptance and the line stays released.
- R7: For a write, the 32 bits of `wdata_i` follow the park bit with `sdo_oe_o`=1, bit 0 first and bit 31 last.
- R8: After bit 31 of a write, one more driven bit carries the XOR of all 32 data bits.
- R9: `done_o` is a single-cycle pulse in the cycle right after the last bit of the transfer (cycle 9 for a read, cycle 42 for a write, counting the first header bit as cycle 1).
- R10: A strobe that occurs during a header, data or data-parity bit is ignored. Fields presented with it do not change the transfer in progress, and no extra transfer follows.
- R11: A strobe during the done cycle is accepted, and its start bit appears in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, sampled with the fields below |
| dbg_sel_i | input | 1 | 1 = debug-port register, 0 = access-port register |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 2 | Register address bits [3:2]; element 0 is address bit 2 |
| wdata_i | input | 32 | Write data, used only when `rd_i` is 0 |
| sdo_o | output | 1 | Serial data toward the line |
| sdo_oe_o | output | 1 | 1 while the host drives the line |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The done cycle of one transfer and the acceptance of the next strobe can fall in the same cycle. This is the case where sequencing errors tend to hide. The bench waits until its reference queue holds only the done entry, then raises the strobe with a new request. The reference model demands the done pulse in that cycle and the new start bit in the next one, with no idle gap. It also demands that strobes held high through a transfer in progress leave the bit stream unchanged.

// File: rtl/swd_req_pkg.sv
package swd_req_pkg;

    localparam int HDR_W     = 8;
    localparam int PAR_IDX   = 5;
    localparam int STOP_IDX  = 6;
    localparam int PARK_IDX  = 7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_DATA,
        PH_DPAR,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic       dbg;
        logic       rd;
        logic [1:0] addr;
    } req_t;

    function automatic logic hdr_parity(input req_t r);
        return r.dbg ^ r.rd ^ r.addr[0] ^ r.addr[1];
    endfunction

    // Header in wire order, element 0 leaves first.
    function automatic logic [HDR_W-1:0] hdr_word(input req_t r);
        logic [HDR_W-1:0] w;
        w           = '0;
        w[0]        = 1'b1;
        w[1]        = r.dbg;
        w[2]        = r.rd;
        w[3]        = r.addr[0];
        w[4]        = r.addr[1];
        w[PAR_IDX]  = hdr_parity(r);
        w[STOP_IDX] = 1'b0;
        w[PARK_IDX] = 1'b0;
        return w;
    endfunction

endpackage

// File: rtl/swd_req_frame.sv
module swd_req_frame
    import swd_req_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int FR_W  = HDR_W + DATA_W + 1
) (
    input  req_t              req_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [FR_W-1:0]   frame_o
);

    logic [HDR_W-1:0] hdr;
    logic             dpar;

    always_comb begin
        hdr  = hdr_word(req_i);
        dpar = ^wdata_i;
        frame_o = {dpar, wdata_i, hdr};
    end

endmodule

// File: rtl/swd_req_seq.sv
module swd_req_seq
    import swd_req_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = ($clog2(DATA_W) > 3) ? $clog2(DATA_W) : 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             rd_i,
    output phase_e           phase_o,
    output logic [CNT_W-1:0] idx_o,
    output logic             load_o,
    output logic             shift_o
);

    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] idx_q;
    logic             rd_q;

    always_comb begin
        load_o  = start_i && (phase_q == PH_IDLE || phase_q == PH_DONE);
        shift_o = (phase_q == PH_HDR) || (phase_q == PH_DATA) || (phase_q == PH_DPAR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            rd_q    <= 1'b0;
        end else if (load_o) begin
            phase_q <= PH_HDR;
            idx_q   <= '0;
            rd_q    <= rd_i;
        end else begin
            unique case (phase_q)
                PH_HDR: begin
                    if (idx_q == HDR_LAST) begin
                        idx_q   <= '0;
                        phase_q <= rd_q ? PH_DONE : PH_DATA;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (idx_q == DATA_LAST) begin
                        idx_q   <= '0;
                        phase_q <= PH_DPAR;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                PH_DPAR: phase_q <= PH_DONE;
                PH_DONE: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign idx_o   = idx_q;

    // R6: a read leaves the header straight for the done cycle
    p_read_no_data_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HDR && idx_q == HDR_LAST && rd_q && !start_i) |=> (phase_q == PH_DONE));

    // R8: exactly one data-parity cycle, then done
    p_dpar_single_r8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DPAR) |=> (phase_q == PH_DONE));

    // R10: a strobe mid-data never aborts or restarts the transfer
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DATA && start_i) |=> (phase_q == PH_DATA || phase_q == PH_DPAR));

endmodule

// File: rtl/swd_req_shift.sv
module swd_req_shift #(
    parameter int W = 41
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] frame_i,
    output logic         bit_o
);

    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)          sr_q <= '0;
        else if (load_i)  sr_q <= frame_i;
        else if (shift_i) sr_q <= {1'b0, sr_q[W-1:1]};
    end

    assign bit_o = sr_q[0];

endmodule

// File: rtl/swd_req_ser.sv
module swd_req_ser
    import swd_req_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              dbg_sel_i,
    input  logic              rd_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              done_o
);

    localparam int FR_W  = HDR_W + DATA_W + 1;
    localparam int CNT_W = ($clog2(DATA_W) > 3) ? $clog2(DATA_W) : 3;
    localparam logic [CNT_W-1:0] PARK_POS = CNT_W'(PARK_IDX);
    localparam logic [CNT_W-1:0] STOP_POS = CNT_W'(STOP_IDX);

    req_t             req;
    logic [FR_W-1:0]  frame;
    phase_e           phase;
    logic [CNT_W-1:0] idx;
    logic             load, shift, sr_bit, drive;

    always_comb begin
        req.dbg  = dbg_sel_i;
        req.rd   = rd_i;
        req.addr = addr_i;
    end

    swd_req_frame #(.DATA_W(DATA_W)) u_frame (
        .req_i   (req),
        .wdata_i (wdata_i),
        .frame_o (frame)
    );

    swd_req_seq #(.DATA_W(DATA_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .rd_i    (rd_i),
        .phase_o (phase),
        .idx_o   (idx),
        .load_o  (load),
        .shift_o (shift)
    );

    swd_req_shift #(.W(FR_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .shift_i (shift),
        .frame_i (frame),
        .bit_o   (sr_bit)
    );

    always_comb begin
        drive    = ((phase == PH_HDR) && (idx != PARK_POS))
                || (phase == PH_DATA) || (phase == PH_DPAR);
        sdo_oe_o = drive;
        sdo_o    = drive & sr_bit;
        done_o   = (phase == PH_DONE);
    end

    // R2: the cycle after an accepted strobe drives the start bit high
    p_start_bit_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (sdo_o && sdo_oe_o));

    // R4: stop bit is driven low
    p_stop_low_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HDR && idx == STOP_POS) |-> (sdo_oe_o && !sdo_o));

    // R5: a released line is never shown as a one
    p_released_low_r5: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe_o |-> !sdo_o);

    // R9: done lasts exactly one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: the line is released while done is high
    p_done_released_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !sdo_oe_o);

endmodule

// File: tb/swd_req_ser_bench.sv
module swd_req_ser_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic        dbg_sel_i;
    logic        rd_i;
    logic [1:0]  addr_i;
    logic [31:0] wdata_i;
    logic        sdo_o, sdo_oe_o, done_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    bit [2:0] eq[$];   // {sdo, oe, done}
    string    tq[$];
    bit       ign_flag  = 0;
    bit       last_done = 0;

    always #5 clk = ~clk;

    swd_req_ser u_swd_req_ser (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .dbg_sel_i (dbg_sel_i),
        .rd_i      (rd_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .sdo_o     (sdo_o),
        .sdo_oe_o  (sdo_oe_o),
        .done_o    (done_o)
    );

    task automatic push(input bit v, input bit oe, input bit d, input string t);
        eq.push_back({v, oe, d});
        tq.push_back(t);
    endtask

    task automatic build(input bit dbg, input bit rd, input bit [1:0] a,
                         input bit [31:0] d, input bit b2b);
        push(1'b1, 1'b1, 1'b0, b2b ? "R11" : "R2");
        push(dbg,  1'b1, 1'b0, "R2");
        push(rd,   1'b1, 1'b0, "R2");
        push(a[0], 1'b1, 1'b0, "R2");
        push(a[1], 1'b1, 1'b0, "R2");
        push(dbg ^ rd ^ a[0] ^ a[1], 1'b1, 1'b0, "R3");
        push(1'b0, 1'b1, 1'b0, "R4");
        push(1'b0, 1'b0, 1'b0, "R5");
        if (!rd) begin
            for (int i = 0; i < 32; i++) push(d[i], 1'b1, 1'b0, "R7");
            push(^d, 1'b1, 1'b0, "R8");
            push(1'b0, 1'b0, 1'b1, "R9");
        end else begin
            push(1'b0, 1'b0, 1'b1, "R6");
        end
    endtask

    // reference model: acceptance decision at the clock edge
    always @(posedge clk) begin
        cyc++;
        ign_flag <= 1'b0;
        if (rst) begin
            eq.delete();
            tq.delete();
        end else if (start_i) begin
            if (eq.size() == 0) build(dbg_sel_i, rd_i, addr_i, wdata_i, last_done);
            else ign_flag <= 1'b1;
        end
    end

    // comparison away from the active edge
    always @(negedge clk) begin
        bit [2:0] exp;
        bit [2:0] got;
        string    tag;
        got = {sdo_o, sdo_oe_o, done_o};
        if (rst) begin
            exp = 3'b000;
            tag = "R1";
            last_done = 0;
        end else if (eq.size() > 0) begin
            exp = eq.pop_front();
            tag = tq.pop_front();
            last_done = exp[0];
        end else begin
            exp = 3'b000;
            tag = "R5";
            last_done = 0;
        end
        if (ign_flag) tag = "R10";
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: {sdo,oe,done} got %b expected %b at cycle %0d", tag, got, exp, cyc);
        end
    end

    always @(posedge clk) begin
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog: got no end, expected finish before cycle 50000");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic drive(input bit dbg, input bit rd, input bit [1:0] a, input bit [31:0] d);
        dbg_sel_i = dbg; rd_i = rd; addr_i = a; wdata_i = d;
    endtask

    task automatic wait_idle();
        while (eq.size() != 0) begin
            @(posedge clk); #2;
        end
        @(posedge clk); #2;
    endtask

    task automatic send(input bit dbg, input bit rd, input bit [1:0] a, input bit [31:0] d);
        @(posedge clk); #2;
        drive(dbg, rd, a, d);
        start_i = 1'b1;
        @(posedge clk); #2;
        start_i = 1'b0;
        drive(~dbg, ~rd, ~a, ~d);
    endtask

    // second request raised exactly in the done cycle of the first (R11)
    task automatic chain(input bit rd1, input bit rd2, input bit [31:0] d1, input bit [31:0] d2);
        send(1'b1, rd1, 2'b10, d1);
        while (!(eq.size() == 1 && eq[0][0])) begin
            @(posedge clk); #2;
        end
        drive(1'b0, rd2, 2'b01, d2);
        start_i = 1'b1;
        @(posedge clk); #2;
        start_i = 1'b0;
        wait_idle();
    endtask

    initial begin
        rst = 1'b1;
        start_i = 1'b0;
        drive(1'b0, 1'b0, 2'b00, 32'h0);
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        repeat (3) @(posedge clk);

        // R2 R3 R6: every read header
        for (int k = 0; k < 8; k++) begin
            send(k[2], 1'b1, k[1:0], 32'hDEAD_0000 + k);
            wait_idle();
        end

        // R7 R8: writes with varied data and fields
        send(1'b0, 1'b0, 2'b00, 32'h0000_0000); wait_idle();
        send(1'b1, 1'b0, 2'b11, 32'hFFFF_FFFF); wait_idle();
        send(1'b0, 1'b0, 2'b01, 32'h8000_0001); wait_idle();
        send(1'b1, 1'b0, 2'b10, 32'hA5A5_0F0F); wait_idle();
        send(1'b0, 1'b0, 2'b11, 32'h1234_5679); wait_idle();

        // R10: strobe held through a write while the fields churn
        @(posedge clk); #2;
        drive(1'b1, 1'b0, 2'b01, 32'hCAFE_F00D);
        start_i = 1'b1;
        for (int j = 0; j < 30; j++) begin
            @(posedge clk); #2;
            drive(j[0], j[1], j[3:2], 32'h0101_0101 * j);
        end
        start_i = 1'b0;
        wait_idle();

        // R11: back-to-back in every read/write pairing
        chain(1'b0, 1'b1, 32'h0F0F_F0F0, 32'h0);
        chain(1'b1, 1'b0, 32'h0,         32'h7FFF_FFFE);
        chain(1'b1, 1'b1, 32'h0,         32'h0);
        chain(1'b0, 1'b0, 32'h5555_AAAA, 32'h0000_0003);

        repeat (4) @(posedge clk);
        #2;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule